// File: doc/BRIEF.md
# Interleaved Block-Fill Sequencer

This block fetches a four-word cache block from a main memory made of four independent banks that share a one-word data bus. Word addresses are spread across the banks by their two lowest bits, so the four words of an aligned block sit in four different banks. When a fill is accepted, the sequencer spends one cycle presenting the block address to the banks. In the default interleaved mode all four banks then run their 15-cycle access together, and the four words drain over the shared bus one per cycle. The whole miss penalty is 20 cycles.

A mode input selects a one-word-wide, non-interleaved discipline instead. In that mode only one bank is accessed at a time, and each word costs a full access plus a transfer, which gives 65 cycles. The block measures the length of every fill and reports it, so the two penalties can be compared directly. The bank contents are modelled inside the bank models as a fixed function of the word address.

Top module: `block_fill_seq`

## Requirements
- R1: After reset, busy_o, word_vld_o and done_o are 0, and penalty_o is 0.
- R2: A request with req_i high is accepted only at a clock edge where busy_o is 0. busy_o is 1 from the following cycle until the end of the done cycle.
- R3: The low two bits of blk_addr_i are ignored, giving base B = blk_addr_i with bits [1:0] cleared. Words are delivered in increasing address order B, B+1, B+2, B+3. word_bank_o is 0, 1, 2, 3 respectively, equal to address bits [1:0]. A word at address A carries {~A, A}: A in bits [15:0] and its bitwise inverse in bits [31:16].
- R4: Cycle 1 is the cycle after the accepting edge. In interleaved mode (mode_narrow_i = 0) word_vld_o is high in exactly cycles 17, 18, 19 and 20.
- R5: In narrow mode (mode_narrow_i = 1) word_vld_o is high in exactly cycles 17, 33, 49 and 65.
- R6: done_o is a one-cycle pulse in the cycle after the last word (cycle 21 or 66). busy_o is 0 in the following cycle.
- R7: While busy_o is 1, including the done cycle, req_i, blk_addr_i and mode_narrow_i have no effect on the fill in progress.
- R8: penalty_o shows the number of cycles from cycle 1 through the last word, which is 20 interleaved or 65 narrow. The value appears in the done cycle and holds until the next fill completes.
- R9: The mode is sampled at the accepting edge. Changing mode_narrow_i during a fill changes neither its timing nor its penalty.
- R10: A request held high across a fill is accepted at the edge that ends the first idle cycle after done, so busy_o is 0 for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Fill request |
| blk_addr_i | input | ADDR_W | Word address of the block; low two bits ignored |
| mode_narrow_i | input | 1 | 1 selects one-word-wide non-interleaved timing |
| busy_o | output | 1 | A fill is in progress |
| word_vld_o | output | 1 | word_data_o carries a block word this cycle |
| word_bank_o | output | $clog2(NUM_BANKS) | Bank (word position) of the current word |
| word_data_o | output | DATA_W | Block word being transferred |
| done_o | output | 1 | One-cycle pulse after the last word |
| penalty_o | output | PEN_W | Cycle count of the most recent completed fill |

## Verification
The bench drives an unaligned block address and checks that the delivered words still start at bank 0. A design that kept the low address bits would return shifted or wrapped data. It switches the mode and changes the address in the middle of a narrow fill while holding the request high. A design that resampled its inputs during a fill would change speed partway, fetch the wrong block, or start a second fill before done. The exact cycles of each word and of the done pulse are compared on every clock against a timing model, so an access counter that is off by one, or a narrow mode that still overlaps the bank accesses, shows up as a misplaced word and a penalty other than 20 or 65. The bench also fetches the highest block in the address space, to catch carries out of the bank-select bits.

// File: rtl/fill_pkg.sv
package fill_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_WAIT,
        ST_XFER,
        ST_DONE
    } fill_state_e;

endpackage

// File: rtl/fill_bank.sv
module fill_bank #(
    parameter int ADDR_W  = 16,
    parameter int SEL_W   = 2,
    parameter int DATA_W  = 32,
    parameter int ACC_CYC = 15,
    parameter int BANK_ID = 0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic [ADDR_W-SEL_W-1:0] row_i,
    output logic                    fin_o,
    output logic [DATA_W-1:0]       data_o
);
    localparam int ROW_W = ADDR_W - SEL_W;
    localparam int CNT_W = $clog2(ACC_CYC + 1);

    typedef struct packed {
        logic              active;
        logic [CNT_W-1:0]  cnt;
        logic [ROW_W-1:0]  row;
        logic [DATA_W-1:0] data;
    } bank_t;

    bank_t bank_d, bank_q;

    // Stored word at address a: address bits repeated, every other copy inverted
    function automatic logic [DATA_W-1:0] word_at(input logic [ADDR_W-1:0] a);
        logic [DATA_W-1:0] v;
        for (int i = 0; i < DATA_W; i++) begin
            v[i] = a[i % ADDR_W] ^ (((i / ADDR_W) % 2) == 1);
        end
        return v;
    endfunction

    always_comb begin
        bank_d = bank_q;
        if (start_i) begin
            bank_d.active = 1'b1;
            bank_d.cnt    = CNT_W'(ACC_CYC);
            bank_d.row    = row_i;
        end else if (bank_q.active) begin
            bank_d.cnt = bank_q.cnt - 1'b1;
            if (bank_q.cnt == CNT_W'(1)) begin
                bank_d.active = 1'b0;
                bank_d.data   = word_at({bank_q.row, SEL_W'(BANK_ID)});
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign fin_o  = bank_q.active && (bank_q.cnt == CNT_W'(1));
    assign data_o = bank_q.data;

    // A bank is never restarted while its access is still running
    assert_bank_start_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !bank_q.active);

    // After the final access cycle the bank is free again
    assert_bank_fin_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fin_o |=> !bank_q.active);

endmodule

// File: rtl/fill_ctrl.sv
module fill_ctrl
    import fill_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int NB     = 4,
    parameter int SEL_W  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_i,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic                    narrow_i,
    input  logic [NB-1:0]           fin_i,
    output logic [NB-1:0]           start_o,
    output logic [ADDR_W-SEL_W-1:0] row_o,
    output logic                    busy_o,
    output logic                    vld_o,
    output logic [SEL_W-1:0]        idx_o,
    output logic                    last_o,
    output logic                    run_o,
    output logic                    done_o
);
    localparam int ROW_W = ADDR_W - SEL_W;
    localparam logic [SEL_W-1:0] LAST_IDX = SEL_W'(NB - 1);

    typedef struct packed {
        fill_state_e      st;
        logic             narrow;
        logic [ROW_W-1:0] row;
        logic [SEL_W-1:0] idx;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;
    logic  ready;

    always_comb begin
        ctl_d   = ctl_q;
        start_o = '0;
        ready   = 1'b0;
        case (ctl_q.st)
            ST_IDLE: begin
                if (req_i) begin
                    ctl_d.st     = ST_ADDR;
                    ctl_d.row    = addr_i[ADDR_W-1:SEL_W];
                    ctl_d.narrow = narrow_i;
                    ctl_d.idx    = '0;
                end
            end
            ST_ADDR: begin
                for (int b = 0; b < NB; b++) begin
                    start_o[b] = ctl_q.narrow ? (b == 0) : 1'b1;
                end
                ctl_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                ready = ctl_q.narrow ? fin_i[ctl_q.idx] : (&fin_i);
                if (ready) begin
                    ctl_d.st = ST_XFER;
                end
            end
            ST_XFER: begin
                if (ctl_q.idx == LAST_IDX) begin
                    ctl_d.st = ST_DONE;
                end else begin
                    ctl_d.idx = ctl_q.idx + 1'b1;
                    if (ctl_q.narrow) begin
                        // next bank's address goes out while this word is on the bus
                        for (int b = 0; b < NB; b++) begin
                            start_o[b] = (SEL_W'(b) == ctl_d.idx);
                        end
                        ctl_d.st = ST_WAIT;
                    end
                end
            end
            ST_DONE: begin
                ctl_d.st = ST_IDLE;
            end
            default: begin
                ctl_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, narrow: 1'b0, row: '0, idx: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign row_o  = ctl_q.row;
    assign idx_o  = ctl_q.idx;
    assign busy_o = (ctl_q.st != ST_IDLE);
    assign vld_o  = (ctl_q.st == ST_XFER);
    assign last_o = vld_o && (ctl_q.idx == LAST_IDX);
    assign run_o  = (ctl_q.st == ST_ADDR) || (ctl_q.st == ST_WAIT) || (ctl_q.st == ST_XFER);
    assign done_o = (ctl_q.st == ST_DONE);

    // Interleaved words leave on consecutive cycles in rising bank order
    assert_word_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_o && !ctl_q.narrow && ctl_q.idx != LAST_IDX)
            |=> (vld_o && ctl_q.idx == $past(ctl_q.idx) + 1'b1));

    // The last word is followed by a single done cycle, then idle
    assert_done_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |=> done_o);
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));

    // Block address and mode stay frozen for the whole fill
    assert_addr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(ctl_q.row));
    assert_mode_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(ctl_q.narrow));

endmodule

// File: rtl/fill_meter.sv
module fill_meter #(
    parameter int PEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             last_i,
    output logic [PEN_W-1:0] pen_o
);
    localparam logic [PEN_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [PEN_W-1:0] cnt;
        logic [PEN_W-1:0] pen;
    } meter_t;

    meter_t met_d, met_q;
    logic [PEN_W-1:0] cnt_inc;

    always_comb begin
        met_d   = met_q;
        cnt_inc = (met_q.cnt == CNT_MAX) ? met_q.cnt : met_q.cnt + 1'b1;
        if (last_i) begin
            met_d.pen = cnt_inc;
            met_d.cnt = '0;
        end else if (run_i) begin
            met_d.cnt = cnt_inc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            met_q <= '0;
        end else begin
            met_q <= met_d;
        end
    end

    assign pen_o = met_q.pen;

    // The running count restarts after every completed fill
    assert_meter_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        last_i |=> (met_q.cnt == '0));

    // The reported penalty only moves when a fill completes
    assert_meter_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !last_i |=> $stable(met_q.pen));

endmodule

// File: rtl/block_fill_seq.sv
module block_fill_seq #(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 32,
    parameter int NUM_BANKS = 4,
    parameter int ACC_CYC   = 15,
    parameter int PEN_W     = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_i,
    input  logic [ADDR_W-1:0]            blk_addr_i,
    input  logic                         mode_narrow_i,
    output logic                         busy_o,
    output logic                         word_vld_o,
    output logic [$clog2(NUM_BANKS)-1:0] word_bank_o,
    output logic [DATA_W-1:0]            word_data_o,
    output logic                         done_o,
    output logic [PEN_W-1:0]             penalty_o
);
    localparam int SEL_W = $clog2(NUM_BANKS);
    localparam int ROW_W = ADDR_W - SEL_W;

    logic [NUM_BANKS-1:0] bank_start;
    logic [NUM_BANKS-1:0] bank_fin;
    logic [DATA_W-1:0]    bank_data [NUM_BANKS];
    logic [ROW_W-1:0]     row;
    logic                 last_word;
    logic                 run;

    fill_ctrl #(
        .ADDR_W (ADDR_W),
        .NB     (NUM_BANKS),
        .SEL_W  (SEL_W)
    ) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (req_i),
        .addr_i   (blk_addr_i),
        .narrow_i (mode_narrow_i),
        .fin_i    (bank_fin),
        .start_o  (bank_start),
        .row_o    (row),
        .busy_o   (busy_o),
        .vld_o    (word_vld_o),
        .idx_o    (word_bank_o),
        .last_o   (last_word),
        .run_o    (run),
        .done_o   (done_o)
    );

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        fill_bank #(
            .ADDR_W  (ADDR_W),
            .SEL_W   (SEL_W),
            .DATA_W  (DATA_W),
            .ACC_CYC (ACC_CYC),
            .BANK_ID (g)
        ) bank_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .start_i (bank_start[g]),
            .row_i   (row),
            .fin_o   (bank_fin[g]),
            .data_o  (bank_data[g])
        );
    end

    // shared one-word bus: the selected bank drives it
    assign word_data_o = bank_data[word_bank_o];

    fill_meter #(
        .PEN_W (PEN_W)
    ) meter_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .last_i (last_word),
        .pen_o  (penalty_o)
    );

    // Words appear only inside a fill
    assert_vld_in_fill_R2: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld_o |-> busy_o);

    // A new fill never starts straight out of the done cycle
    assert_idle_after_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);

endmodule

// File: tb/block_fill_seq_tb.sv
`timescale 1ns/1ps
module block_fill_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [15:0] addr = '0;
    logic        narrow = 1'b0;
    logic        busy, vld, done;
    logic [1:0]  bank;
    logic [31:0] data;
    logic [7:0]  pen;

    int checks = 0;
    int errors = 0;
    bit chk_en = 1'b0;

    always #2 clk = ~clk;

    block_fill_seq dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_i         (req),
        .blk_addr_i    (addr),
        .mode_narrow_i (narrow),
        .busy_o        (busy),
        .word_vld_o    (vld),
        .word_bank_o   (bank),
        .word_data_o   (data),
        .done_o        (done),
        .penalty_o     (pen)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural timing model ----------------
    bit          m_busy = 1'b0;
    bit          m_narrow = 1'b0;
    int          m_t = 0;
    int          m_pen = 0;
    logic [15:0] m_base = '0;

    function automatic int end_cycle(bit n);
        return n ? 66 : 21;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 1'b0; m_t = 0; m_pen = 0;
        end else if (m_busy) begin
            if (m_t == end_cycle(m_narrow)) begin
                m_busy = 1'b0; m_t = 0;
            end else begin
                m_t++;
                if (m_t == end_cycle(m_narrow)) m_pen = end_cycle(m_narrow) - 1;
            end
        end else if (req) begin
            m_busy = 1'b1; m_t = 1; m_narrow = narrow;
            m_base = {addr[15:2], 2'b00};
        end
    end

    always @(negedge clk) begin
        if (chk_en) begin
            bit          e_vld;
            int          e_idx;
            logic [15:0] a;
            if (m_narrow) begin
                e_vld = m_busy && m_t >= 17 && m_t <= 65 && ((m_t - 17) % 16 == 0);
                e_idx = (m_t - 17) / 16;
            end else begin
                e_vld = m_busy && m_t >= 17 && m_t <= 20;
                e_idx = m_t - 17;
            end
            check(busy == m_busy, "R2", busy, m_busy);
            check(vld == e_vld, m_narrow ? "R5" : "R4", vld, e_vld);
            check(done == (m_busy && m_t == end_cycle(m_narrow)), "R6", done,
                  m_busy && m_t == end_cycle(m_narrow));
            check(pen == m_pen[7:0], "R8", pen, m_pen);
            if (e_vld && vld) begin
                a = m_base + 16'(e_idx);
                check(bank == e_idx[1:0], "R3", bank, e_idx);
                check(data == {~a, a}, "R3", data, {~a, a});
            end
        end
    end

    // ---------------- word capture ----------------
    logic [31:0] got_q [$];
    always @(negedge clk) begin
        if (vld) got_q.push_back(data);
    end

    task automatic wait_done();
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (done) return;
        end
        check(1'b0, "R6", 0, 1);
    endtask

    task automatic check_block(input string tag, input logic [15:0] base);
        check(got_q.size() == 4, tag, got_q.size(), 4);
        for (int i = 0; i < got_q.size() && i < 4; i++) begin
            logic [15:0] a;
            a = base + 16'(i);
            check(got_q[i] == {~a, a}, tag, got_q[i], {~a, a});
        end
        got_q.delete();
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        check(busy == 1'b0, "R1", busy, 0);
        check(vld == 1'b0, "R1", vld, 0);
        check(done == 1'b0, "R1", done, 0);
        check(pen == 8'd0, "R1", pen, 0);
        rst_n = 1'b1;
        chk_en = 1'b1;
        @(negedge clk);

        // Interleaved fill with unaligned address (R3, R4)
        req = 1'b1; addr = 16'h1236; narrow = 1'b0;
        @(negedge clk);
        req = 1'b0;
        wait_done();
        check(pen == 8'd20, "R8", pen, 20);
        check_block("R3", 16'h1234);
        repeat (3) @(negedge clk);

        // Narrow fill; inputs disturbed during it (R5, R7, R9, R10)
        req = 1'b1; addr = 16'h00A1; narrow = 1'b1;
        @(negedge clk);
        addr = 16'h5552; narrow = 1'b0;  // req stays high: must be ignored while busy
        wait_done();
        check(pen == 8'd65, "R9", pen, 65);
        check_block("R5", 16'h00A0);
        @(negedge clk);
        check(busy == 1'b0, "R6", busy, 0);
        @(negedge clk);
        check(busy == 1'b1, "R10", busy, 1);
        req = 1'b0;
        wait_done();
        check(pen == 8'd20, "R9", pen, 20);
        check_block("R7", 16'h5550);
        repeat (2) @(negedge clk);

        // Top of the address space (R3)
        req = 1'b1; addr = 16'hFFFF; narrow = 1'b0;
        @(negedge clk);
        req = 1'b0;
        wait_done();
        check_block("R3", 16'hFFFC);
        repeat (3) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule